// File: doc/BRIEF.md
# Two-Line Display Address Counter

This block keeps the cursor address and the horizontal view offset for a character display of two lines. Each line holds 40 positions. The first line uses addresses 00h to 27h and the second line uses 40h to 67h. The address space between and after those two ranges is never used.

The block takes decoded instruction strobes, each with its fields. These cover entry-mode set, cursor or display move, return home, clear and address set. It also takes one strobe per data read and one per data write. It keeps the counter inside the two legal ranges at all times. It also applies the entry mode's automatic view shift on writes.

The counter and the view offset are two separate registers. A view shift therefore never disturbs the cursor address. The offset is shared by both lines, so the two lines scroll together.

Top module: `dual_line_addr_unit`

## Requirements
- R1: After reset the address counter is 00h, the view offset is 0, the direction is increment and auto-shift is off. The counter never holds a value outside 00h–27h or 40h–67h.
- R2: Each data read or write steps the counter by one position. It steps up when the direction is increment and down when it is decrement.
- R3: Stepping crosses lines. Up from 27h gives 40h and up from 67h gives 00h. Down from 40h gives 27h and down from 00h gives 67h.
- R4: With auto-shift on, every data write also moves the view offset: +1 when the direction is increment, −1 when it is decrement. A data read never changes the offset.
- R5: A display-move command (`mv_disp`=1) changes the offset by −1 when `mv_right`=1 and by +1 when `mv_right`=0. It leaves the counter unchanged.
- R6: A cursor-move command (`mv_disp`=0) steps the counter up when `mv_right`=1 and down when `mv_right`=0, following R3. It leaves the offset unchanged.
- R7: The view offset stays in 0–39. Moving up from 39 gives 0 and moving down from 0 gives 39.
- R8: Return home sets the counter to 00h and the offset to 0. It leaves the direction and auto-shift settings as they were.
- R9: Clear sets the counter to 00h, the offset to 0 and the direction to increment. It leaves auto-shift as it was.
- R10: Address set loads a legal value as given. A value in 28h–3Fh loads 40h. A value in 68h–7Fh loads 00h.
- R11: When several strobes are high in one cycle, only the highest acts. The order is clear, then home, then address set, then move, then entry-mode set, then data access. A read and a write together count as a single write.
- R12: Every update appears on the outputs at the first rising clock edge after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_req | input | 1 | Clear strobe |
| home_req | input | 1 | Return-home strobe |
| aset_req | input | 1 | Address-set strobe |
| aset_val | input | 7 | Address for address set |
| mv_req | input | 1 | Cursor/display move strobe |
| mv_disp | input | 1 | 1: move the view, 0: move the cursor |
| mv_right | input | 1 | Move direction, 1 = right |
| ent_req | input | 1 | Entry-mode set strobe |
| ent_inc | input | 1 | Direction field, 1 = increment |
| ent_shift | input | 1 | Auto-shift field, 1 = shift the view on each write |
| wr_stb | input | 1 | Data write happened |
| rd_stb | input | 1 | Data read happened |
| ac | output | 7 | Current address counter |
| view_off | output | 6 | Current view offset, 0–39 |

## Verification
Every result is due exactly one rising edge after its strobe. The strobe is raised just after a falling edge and is captured at the next rising edge. The outputs are then sampled at the falling edge that follows, half a period after the update.

The vector table moves the block through line crossings, both wrap points of the offset and the clamp ranges. Each row's expected values come from applying the requirements to the previous row. Separate directed steps cover reset and the simultaneous-strobe priority. In those steps the outputs are read one edge later, so they show that the lower-priority strobe had no effect.

// File: rtl/dla_pkg.sv
package dla_pkg;
  localparam int LINE_LEN   = 40;
  localparam int LINE2_BASE = 'h40;
  localparam int AW = $clog2(LINE2_BASE + LINE_LEN);
  localparam int SW = $clog2(LINE_LEN);

  // One position forward or backward, jumping across the gap between lines.
  function automatic logic [AW-1:0] fn_ac_step(input logic [AW-1:0] a, input logic up,
                                               input int len, input int base2);
    logic [AW-1:0] last1, last2;
    last1 = AW'(len - 1);
    last2 = AW'(base2 + len - 1);
    if (up) begin
      if (a == last1)              return AW'(base2);
      else if (a == last2)         return '0;
      else                         return a + 1'b1;
    end else begin
      if (a == AW'(base2))         return last1;
      else if (a == '0)            return last2;
      else                         return a - 1'b1;
    end
  endfunction

  // Map any address to a legal one: the gap maps to line 2, past the end to 0.
  function automatic logic [AW-1:0] fn_ac_clamp(input logic [AW-1:0] a,
                                                input int len, input int base2);
    if (int'(a) < len)                return a;
    else if (int'(a) < base2)         return AW'(base2);
    else if (int'(a) < base2 + len)   return a;
    else                              return '0;
  endfunction

  // Offset step modulo the line length.
  function automatic logic [SW-1:0] fn_off_step(input logic [SW-1:0] s, input logic up,
                                                input int len);
    if (up) return (s == SW'(len - 1)) ? '0 : s + 1'b1;
    else    return (s == '0) ? SW'(len - 1) : s - 1'b1;
  endfunction
endpackage

// File: rtl/dla_addr_ctr.sv
module dla_addr_ctr
  import dla_pkg::*;
#(
  parameter int LEN   = LINE_LEN,
  parameter int BASE2 = LINE2_BASE,
  parameter int W     = AW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zero_en,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         step_en,
  input  logic         step_up,
  output logic [W-1:0] ac_q
);
  localparam logic [W-1:0] LAST1 = W'(LEN - 1);
  localparam logic [W-1:0] FIRST2 = W'(BASE2);
  localparam logic [W-1:0] LAST2 = W'(BASE2 + LEN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ac_q <= '0;
    else if (zero_en)  ac_q <= '0;
    else if (load_en)  ac_q <= fn_ac_clamp(load_val, LEN, BASE2);
    else if (step_en)  ac_q <= fn_ac_step(ac_q, step_up, LEN, BASE2);
  end

  wire plain_step = step_en && !zero_en && !load_en;

  AST_AC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_q <= LAST1) || (ac_q >= FIRST2 && ac_q <= LAST2)); // R1
  AST_AC_UP_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    plain_step && step_up && ac_q == LAST1 |=> ac_q == FIRST2); // R3
  AST_AC_DN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    plain_step && !step_up && ac_q == '0 |=> ac_q == LAST2); // R3
  AST_AC_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    zero_en |=> ac_q == '0); // R8
endmodule

// File: rtl/dla_view_off.sv
module dla_view_off
  import dla_pkg::*;
#(
  parameter int LEN = LINE_LEN,
  parameter int W   = SW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zero_en,
  input  logic         step_en,
  input  logic         step_up,
  output logic [W-1:0] off_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       off_q <= '0;
    else if (zero_en) off_q <= '0;
    else if (step_en) off_q <= fn_off_step(off_q, step_up, LEN);
  end

  AST_OFF_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    off_q < W'(LEN)); // R7
  AST_OFF_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !zero_en && step_up && off_q == W'(LEN - 1) |=> off_q == '0); // R7
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en && !zero_en |=> $stable(off_q)); // R6
endmodule

// File: rtl/dual_line_addr_unit.sv
module dual_line_addr_unit
  import dla_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_req,
  input  logic          home_req,
  input  logic          aset_req,
  input  logic [AW-1:0] aset_val,
  input  logic          mv_req,
  input  logic          mv_disp,
  input  logic          mv_right,
  input  logic          ent_req,
  input  logic          ent_inc,
  input  logic          ent_shift,
  input  logic          wr_stb,
  input  logic          rd_stb,
  output logic [AW-1:0] ac,
  output logic [SW-1:0] view_off
);
  logic inc_q, autoshift_q;

  // Priority-resolved events (R11)
  wire ev_clear = clear_req;
  wire ev_home  = home_req && !clear_req;
  wire ev_aset  = aset_req && !clear_req && !home_req;
  wire ev_move  = mv_req && !clear_req && !home_req && !aset_req;
  wire ev_entry = ent_req && !clear_req && !home_req && !aset_req && !mv_req;
  wire ev_data  = (wr_stb || rd_stb) && !clear_req && !home_req && !aset_req
                  && !mv_req && !ent_req;
  wire ev_write = ev_data && wr_stb;
  wire ev_cur   = ev_move && !mv_disp;
  wire ev_view  = ev_move && mv_disp;

  wire ac_step_en  = ev_cur || ev_data;
  wire ac_step_up  = ev_cur ? mv_right : inc_q;
  wire off_step_en = ev_view || (ev_write && autoshift_q);
  wire off_step_up = ev_view ? !mv_right : inc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q       <= 1'b1;
      autoshift_q <= 1'b0;
    end else if (ev_clear) begin
      inc_q       <= 1'b1;
    end else if (ev_entry) begin
      inc_q       <= ent_inc;
      autoshift_q <= ent_shift;
    end
  end

  dla_addr_ctr #(.LEN(LINE_LEN), .BASE2(LINE2_BASE), .W(AW)) u_ac (
    .clk(clk), .rst_n(rst_n),
    .zero_en(ev_clear || ev_home), .load_en(ev_aset), .load_val(aset_val),
    .step_en(ac_step_en), .step_up(ac_step_up), .ac_q(ac)
  );

  dla_view_off #(.LEN(LINE_LEN), .W(SW)) u_off (
    .clk(clk), .rst_n(rst_n),
    .zero_en(ev_clear || ev_home), .step_en(off_step_en), .step_up(off_step_up),
    .off_q(view_off)
  );

  AST_VIEW_KEEPS_AC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_view |=> $stable(ac)); // R5
  AST_READ_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data && !wr_stb |=> $stable(view_off)); // R4
  AST_HOME_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    home_req |=> ac == '0 && view_off == '0); // R8
  AST_ENTRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_entry |=> $stable(ac) && $stable(view_off)); // R11
endmodule

// File: tb/dual_line_addr_unit_test.sv
module dual_line_addr_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_req = 0, home_req = 0, aset_req = 0, mv_req = 0, mv_disp = 0, mv_right = 0;
  logic ent_req = 0, ent_inc = 0, ent_shift = 0, wr_stb = 0, rd_stb = 0;
  logic [6:0] aset_val = '0;
  logic [6:0] ac;
  logic [5:0] view_off;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  dual_line_addr_unit uut (
    .clk(clk), .rst_n(rst_n), .clear_req(clear_req), .home_req(home_req),
    .aset_req(aset_req), .aset_val(aset_val), .mv_req(mv_req), .mv_disp(mv_disp),
    .mv_right(mv_right), .ent_req(ent_req), .ent_inc(ent_inc), .ent_shift(ent_shift),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .ac(ac), .view_off(view_off)
  );

  // ops: 0 idle, 1 entry {inc,shift}=arg[1:0], 2 move {disp,right}=arg[1:0],
  //      3 home, 4 clear, 5 address set arg, 6 write, 7 read
  localparam int NV = 36;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {4'd5, 7'h26, 7'h26, 6'd0},   // R10
    {4'd6, 7'h00, 7'h27, 6'd0},   // R2
    {4'd6, 7'h00, 7'h40, 6'd0},   // R3 27->40
    {4'd7, 7'h00, 7'h41, 6'd0},   // R2
    {4'd1, 7'h00, 7'h41, 6'd0},   // decrement, no shift
    {4'd7, 7'h00, 7'h40, 6'd0},
    {4'd6, 7'h00, 7'h27, 6'd0},   // R3 40->27
    {4'd5, 7'h00, 7'h00, 6'd0},
    {4'd6, 7'h00, 7'h67, 6'd0},   // R3 00->67
    {4'd1, 7'h02, 7'h67, 6'd0},
    {4'd6, 7'h00, 7'h00, 6'd0},   // R3 67->00
    {4'd1, 7'h03, 7'h00, 6'd0},
    {4'd6, 7'h00, 7'h01, 6'd1},   // R4
    {4'd7, 7'h00, 7'h02, 6'd1},   // R4 read no shift
    {4'd2, 7'h02, 7'h02, 6'd2},   // R5 left
    {4'd2, 7'h03, 7'h02, 6'd1},   // R5 right
    {4'd2, 7'h03, 7'h02, 6'd0},
    {4'd2, 7'h03, 7'h02, 6'd39},  // R7 0->39
    {4'd2, 7'h02, 7'h02, 6'd0},   // R7 39->0
    {4'd2, 7'h01, 7'h03, 6'd0},   // R6
    {4'd2, 7'h00, 7'h02, 6'd0},   // R6
    {4'd5, 7'h30, 7'h40, 6'd0},   // R10 gap
    {4'd5, 7'h7F, 7'h00, 6'd0},   // R10 past end
    {4'd5, 7'h68, 7'h00, 6'd0},
    {4'd5, 7'h67, 7'h67, 6'd0},
    {4'd2, 7'h02, 7'h67, 6'd1},
    {4'd3, 7'h00, 7'h00, 6'd0},   // R8
    {4'd1, 7'h01, 7'h00, 6'd0},
    {4'd5, 7'h05, 7'h05, 6'd0},
    {4'd6, 7'h00, 7'h04, 6'd39},  // R4 decrement shift
    {4'd5, 7'h40, 7'h40, 6'd39},
    {4'd6, 7'h00, 7'h27, 6'd38},
    {4'd4, 7'h00, 7'h00, 6'd0},   // R9
    {4'd6, 7'h00, 7'h01, 6'd1},   // R9 inc restored, shift kept
    {4'd5, 7'h3F, 7'h40, 6'd1},
    {4'd5, 7'h27, 7'h27, 6'd1}
  };

  task automatic idle_all();
    clear_req = 0; home_req = 0; aset_req = 0; mv_req = 0; ent_req = 0;
    wr_stb = 0; rd_stb = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle_all();
  endtask

  task automatic check(input string tag, input logic [6:0] eac, input logic [5:0] eoff);
    checks++;
    if (ac !== eac || view_off !== eoff) begin
      errors++;
      $display("FAIL %s: ac=%h off=%0d expected ac=%h off=%0d", tag, ac, view_off, eac, eoff);
    end
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 7'h00, 6'd0);
    rst_n = 1'b1;
    @(negedge clk);
    wr_stb = 1; step();
    check("R1 reset direction increment, no shift", 7'h01, 6'd0);
    aset_req = 1; aset_val = 7'h00; step();

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][23:20])
        4'd1: begin ent_req = 1; ent_inc = VEC[i][14]; ent_shift = VEC[i][13]; end
        4'd2: begin mv_req = 1; mv_disp = VEC[i][14]; mv_right = VEC[i][13]; end
        4'd3: home_req = 1;
        4'd4: clear_req = 1;
        4'd5: begin aset_req = 1; aset_val = VEC[i][19:13]; end
        4'd6: wr_stb = 1;
        4'd7: rd_stb = 1;
        default: ;
      endcase
      step();
      check($sformatf("R2/R12 table row %0d", i), VEC[i][12:6], VEC[i][5:0]);
    end

    // R11 priority cases; auto-shift on, increment
    ent_req = 1; ent_inc = 1; ent_shift = 1; step();
    aset_req = 1; aset_val = 7'h10; step();
    home_req = 1; wr_stb = 1; step();
    check("R11 home beats write", 7'h00, 6'd0);
    step();
    check("R11 write had no late effect", 7'h00, 6'd0);
    clear_req = 1; aset_req = 1; aset_val = 7'h22; step();
    check("R11 clear beats address set", 7'h00, 6'd0);
    aset_req = 1; aset_val = 7'h22; mv_req = 1; mv_disp = 0; mv_right = 1; step();
    check("R11 address set beats move", 7'h22, 6'd0);
    mv_req = 1; mv_disp = 1; mv_right = 0; wr_stb = 1; step();
    check("R11 move beats write", 7'h22, 6'd1);
    ent_req = 1; ent_inc = 0; ent_shift = 0; wr_stb = 1; step();
    check("R11 entry set beats write", 7'h22, 6'd1);
    wr_stb = 1; rd_stb = 1; step();
    check("R11 read+write is one step", 7'h21, 6'd1);
    // R8 home keeps mode: decrement, no shift
    home_req = 1; step();
    wr_stb = 1; step();
    check("R8 mode kept after home", 7'h67, 6'd0);
    // R1 reset mid-run
    rst_n = 0; @(negedge clk);
    check("R1 async reset", 7'h00, 6'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule